// File: doc/BRIEF.md
# Interrupt Vector Select Unit

This block runs the vector-select step of an 8-bit CPU's interrupt entry. When the instruction decoder strobes a start, the unit samples the pending interrupt sources in that first cycle and picks the highest-ranked one. It turns the winner into an even code between 0xE0 and 0xFE. That code replaces the low byte of the current program counter, and the high byte is kept, which gives the address of a two-byte slot in a vector table.

The unit then reads the 16-bit vector stored at that slot through a synchronous program-memory read port. It reads the high byte at the even address, then the low byte at the following odd address. It presents the assembled word as the new program counter together with a one-cycle done pulse. While the fetch runs, the unit ignores further start strobes.

The unit also keeps the non-maskable pending flag. The flag ranks just below the software trap. It is set by a request strobe and cleared by a dedicated clear strobe or by reset.

Top module: `ivs_unit`

## Requirements
- R1: When the software trap input is high at the start cycle, the table slot code is 0xFE, whatever the other sources are.
- R2: When the trap is low and the non-maskable pending flag is set at the start cycle, the code is 0xFC.
- R3: With trap and non-maskable pending both clear, request line k (k = 0 is the external interrupt) gives code 0xFA − 2·k. When several lines are high, the lowest index wins.
- R4: When no source is active at the start cycle, the code is the fallback 0xE0.
- R5: The table address is {pc_in[15:8], code}. The first memory read uses that even address and the second read uses the same address with bit 0 set. Every read address has its low byte in 0xE0–0xFF.
- R6: The first read is issued on the edge that accepts the start, and done is high for one cycle on the third edge after that. At done, pc_out equals {byte at the even address, byte at the odd address}. busy stays high from the accepting edge until done rises, and busy is low while done is high.
- R7: The sources and pc_in are sampled only on the accepting edge. Changes to them during the fetch do not alter the vector or the address.
- R8: A start strobe that arrives while busy is high is ignored. It produces no extra memory read and no extra done pulse.
- R9: nmi_pending goes high on the edge after nmi_set and low on the edge after nmi_clr. When both strobes arrive together, set wins.
- R10: A synchronous active-high reset returns the unit to idle, with busy, done and mem_rd low and nmi_pending cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vis_start | input | 1 | Vector-select start strobe from the decoder |
| trap_req | input | 1 | Software trap active |
| irq_req | input | NUM_IRQ | Masked request lines; bit 0 is the external interrupt, and a lower index ranks higher |
| nmi_set | input | 1 | Sets the non-maskable pending flag |
| nmi_clr | input | 1 | Clear-pending instruction strobe |
| pc_in | input | 16 | Current program counter |
| mem_rd | output | 1 | Program-memory read enable |
| mem_addr | output | 16 | Program-memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the read is issued |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle pulse: pc_out holds the new PC |
| pc_out | output | 16 | Vector loaded into the PC |
| nmi_pending | output | 1 | Non-maskable pending flag |

## Verification
The assertions assume that the program memory returns data exactly one cycle after a read and that nmi_set and nmi_clr are single-cycle strobes. They also assume that pc_in is stable at the cycle in which a start is accepted. The stimulus drives every input half a cycle away from the active edge. Its memory model answers each read one cycle later with a byte computed from the address. Request lines, trap and pc_in are scrambled during fetches to show that they no longer matter, and extra starts are pushed only while busy is high.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  localparam logic [7:0] CODE_TRAP = 8'hFE;
  localparam logic [7:0] CODE_NMI  = 8'hFC;
  localparam logic [7:0] CODE_TOP  = 8'hFA;
  localparam logic [7:0] CODE_NONE = 8'hE0;
  // Number of request slots between CODE_TOP and CODE_NONE, exclusive of the latter.
  localparam int unsigned MAX_IRQ  = (CODE_TOP - CODE_NONE) / 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_HI = 2'd1,
    ST_RD_LO = 2'd2,
    ST_LOAD  = 2'd3
  } fetch_st_e;

  function automatic logic [7:0] irq_slot(input int unsigned k);
    return CODE_TOP - 8'(2 * k);
  endfunction
endpackage

// File: rtl/ivs_rank.sv
module ivs_rank
  import ivs_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 13
) (
  input  logic               trap,
  input  logic               nmi,
  input  logic [NUM_IRQ-1:0] irq,
  output logic [7:0]         code
);
  // Per-line slot codes, fixed at elaboration.
  logic [7:0] slot [NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_slot
    assign slot[g] = irq_slot(g);
  end

  // Walk from the lowest rank upward so the highest-ranked active source is written last.
  always_comb begin
    code = CODE_NONE;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (irq[k]) code = slot[k];
    end
    if (nmi)  code = CODE_NMI;
    if (trap) code = CODE_TRAP;
  end
endmodule

// File: rtl/ivs_nmi_flag.sv
module ivs_nmi_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/ivs_fetch.sv
module ivs_fetch
  import ivs_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [7:0]      code,
  input  logic [AW-9:0]   pc_hi,
  input  logic [DW-1:0]   rdata,
  output logic            rd,
  output logic [AW-1:0]   addr,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] vec
);
  fetch_st_e   st;
  logic [DW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      rd   <= 1'b0;
      addr <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      vec  <= '0;
      hi_q <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            addr <= {pc_hi, code};
            rd   <= 1'b1;
            busy <= 1'b1;
            st   <= ST_RD_HI;
          end
        end
        ST_RD_HI: begin
          addr[0] <= 1'b1;
          st      <= ST_RD_LO;
        end
        ST_RD_LO: begin
          hi_q <= rdata;
          rd   <= 1'b0;
          st   <= ST_LOAD;
        end
        ST_LOAD: begin
          vec  <= {hi_q, rdata};
          done <= 1'b1;
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ivs_unit.sv
module ivs_unit
  import ivs_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vis_start,
  input  logic               trap_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               nmi_set,
  input  logic               nmi_clr,
  input  logic [15:0]        pc_in,
  output logic               mem_rd,
  output logic [15:0]        mem_addr,
  input  logic [7:0]         mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [15:0]        pc_out,
  output logic               nmi_pending
);
  logic [7:0] code;
  logic       pc_lo_unused;

  assign pc_lo_unused = ^pc_in[7:0];

  ivs_nmi_flag u_nmi (
    .clk    (clk),
    .rst    (rst),
    .set_i  (nmi_set),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pending)
  );

  ivs_rank #(.NUM_IRQ(NUM_IRQ)) u_rank (
    .trap (trap_req),
    .nmi  (nmi_pending),
    .irq  (irq_req),
    .code (code)
  );

  ivs_fetch #(.AW(16), .DW(8)) u_fetch (
    .clk   (clk),
    .rst   (rst),
    .start (vis_start),
    .code  (code),
    .pc_hi (pc_in[15:8]),
    .rdata (mem_rdata),
    .rd    (mem_rd),
    .addr  (mem_addr),
    .busy  (busy),
    .done  (done),
    .vec   (pc_out)
  );
endmodule

// File: rtl/ivs_unit_chk.sv
module ivs_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        nmi_set,
  input logic        nmi_clr,
  input logic [15:0] pc_in,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic        busy,
  input logic        done,
  input logic        nmi_pending
);
  // R10: reset leaves the unit idle with the flag clear
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_rd && !nmi_pending));

  // R9: set strobe raises the flag
  a_r9_set: assert property (@(posedge clk) disable iff (rst)
    nmi_set |=> nmi_pending);

  // R9: clear strobe alone drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (nmi_clr && !nmi_set) |=> !nmi_pending);

  // R5: every read lands in the vector table window
  a_r5_window: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr[7:5] == 3'b111));

  // R5: first read keeps the PC high byte and is even
  a_r5_base: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mem_addr[15:8] == $past(pc_in[15:8]) && !mem_addr[0]));

  // R6: done is a single-cycle pulse
  a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: done only once the fetch has finished
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_rd));

  // R8: reads occur only inside a fetch
  a_r8_rd_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);
endmodule

bind ivs_unit ivs_unit_chk u_chk (.*);

// File: tb/ivs_unit_bench.sv
module ivs_unit_bench;
  localparam int N = 13;

  logic          clk = 1'b0;
  logic          rst;
  logic          vis_start, trap_req, nmi_set, nmi_clr;
  logic [N-1:0]  irq_req;
  logic [15:0]   pc_in;
  logic          mem_rd;
  logic [15:0]   mem_addr;
  logic [7:0]    mem_rdata;
  logic          busy, done, nmi_pending;
  logic [15:0]   pc_out;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        nmi_model = 1'b0;

  always #10 clk = ~clk;

  ivs_unit #(.NUM_IRQ(N)) u_ivs_unit (.*);

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_f(mem_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(input logic t, input logic nm, input logic [N-1:0] r);
    if (t) return 8'hFE;
    if (nm) return 8'hFC;
    for (int k = 0; k < N; k++) if (r[k]) return 8'(8'hFA - 2 * k);
    return 8'hE0;
  endfunction

  // Monitor: scoreboard side
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check("R8 spurious done", 32'd1, 32'd0);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {16'h0, pc_out}, {16'h0, e});
      end
    end
  end

  // Driver: pushes expected vector, runs one fetch, scrambles inputs while busy
  task automatic vis(input logic [15:0] pc, input logic t, input logic [N-1:0] r,
                     input string tag, input bit poke);
    logic [15:0] base;
    int cyc;
    @(negedge clk);
    base = {pc[15:8], exp_code(t, nmi_model, r)};
    exp_q.push_back({mem_f(base), mem_f(base | 16'h1)});
    tag_q.push_back(tag);
    pc_in = pc; trap_req = t; irq_req = r; vis_start = 1'b1;
    @(negedge clk);
    vis_start = 1'b0;
    check("R6 busy after start", {31'h0, busy}, 32'd1);
    check("R5 first address", {16'h0, mem_addr}, {16'h0, base});
    // R7: scramble sources and PC during the fetch
    trap_req = ~t; irq_req = ~r; pc_in = ~pc;
    if (poke) vis_start = 1'b1;   // R8: start while busy
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      vis_start = 1'b0;
      cyc++;
    end
    check("R6 latency", cyc, 4);
    check("R6 busy low at done", {31'h0, busy}, 32'd0);
    trap_req = 1'b0; irq_req = '0;
  endtask

  initial begin
    rst = 1'b1; vis_start = 0; trap_req = 0; nmi_set = 0; nmi_clr = 0;
    irq_req = '0; pc_in = 16'h0000;
    repeat (3) @(negedge clk);
    check("R10 reset busy", {31'h0, busy}, 0);
    check("R10 reset done", {31'h0, done}, 0);
    check("R10 reset rd", {31'h0, mem_rd}, 0);
    rst = 1'b0;
    @(negedge clk);

    vis(16'h1234, 1'b1, 13'h1FFF, "R1 trap", 0);
    vis(16'hAB00, 1'b0, 13'h0001, "R3 external", 0);
    vis(16'h5599, 1'b0, 13'h0000, "R4 fallback", 0);
    vis(16'h7F10, 1'b0, 13'h1000, "R3 lowest line", 0);
    vis(16'h0042, 1'b0, 13'h0A28, "R3 lowest index wins", 0);
    for (int k = 1; k < N; k += 3)
      vis(16'(16'h3000 + k * 16'h0100), 1'b0, 13'(1 << k), "R3 line slot", 0);

    // R9 set then vector with pending
    @(negedge clk); nmi_set = 1'b1;
    @(negedge clk); nmi_set = 1'b0; nmi_model = 1'b1;
    check("R9 set", {31'h0, nmi_pending}, 1);
    vis(16'hC0DE, 1'b0, 13'h0003, "R2 nmi over irq", 0);
    vis(16'hC1DE, 1'b1, 13'h0003, "R1 trap over nmi", 0);
    @(negedge clk); nmi_clr = 1'b1;
    @(negedge clk); nmi_clr = 1'b0; nmi_model = 1'b0;
    check("R9 clear", {31'h0, nmi_pending}, 0);
    @(negedge clk); nmi_clr = 1'b1; nmi_set = 1'b1;
    @(negedge clk); nmi_clr = 1'b0; nmi_set = 1'b0; nmi_model = 1'b1;
    check("R9 set wins", {31'h0, nmi_pending}, 1);
    @(negedge clk); nmi_clr = 1'b1;
    @(negedge clk); nmi_clr = 1'b0; nmi_model = 1'b0;

    // R8: start while busy ignored
    vis(16'h9900, 1'b0, 13'h0004, "R8 poke fetch", 1);
    repeat (6) begin
      @(negedge clk);
      check("R8 no extra read", {31'h0, mem_rd}, 0);
    end
    check("R8 queue drained", exp_q.size(), 0);

    // R10: reset clears pending
    @(negedge clk); nmi_set = 1'b1;
    @(negedge clk); nmi_set = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0; nmi_model = 1'b0;
    check("R10 reset clears flag", {31'h0, nmi_pending}, 0);
    check("R10 reset idle", {31'h0, busy}, 0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule